// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the integer execution stage of a small 32-bit load/store processor core. Each cycle it receives a 32-bit instruction word together with the values of its two source registers, already read from the register file by the surrounding pipeline. It decodes the primary opcode field and, for register-form words, the function field. It then picks the second operand: either the register value or the 16-bit immediate, widened with sign or zero fill. The unit computes the result and registers it, along with an illegal-instruction flag and a signed-overflow flag.

The operations are add and subtract (with and without overflow reporting), the four bitwise operations, signed set-on-less-than, logical and arithmetic shifts by a constant or by a register amount, and loading a constant into the upper half of a word. The overflow flag is only reported: no trap is raised, and the result is still written. Register-file access, memory, branches and multiply/divide are handled elsewhere. The register-number fields of the word are ignored because the operand values arrive already read.

Internally the block has a single state: the result register. It is either in its reset value or holds the outcome of the word presented one clock earlier. There is no other sequencing.

Top module: `exu_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, result_o is zero and illegal_o and ovf_o are low.
- R2: Outputs are registered. The outputs that follow a rising clock edge reflect the instruction and operand values that were present at that edge.
- R3: With opcode instr[31:26]=0, function code instr[5:0] selects the operation: 32 adds, 33 adds without overflow, 34 subtracts rs−rt, 35 subtracts without overflow.
- R4: With opcode 0, function codes 36, 37, 38 and 39 give AND, OR, XOR and NOR of the rs and rt values.
- R5: Function 42 (opcode 0) and opcode 10 give 1 when the rs value is less than the second operand, compared as signed two's complement numbers, and 0 otherwise.
- R6: Function codes 0, 2 and 3 (opcode 0) shift the rt value left logically, right logically and right arithmetically by the constant in instr[10:6].
- R7: Function codes 4, 6 and 7 (opcode 0) perform the same three shifts on the rt value, using rs value bits [4:0] as the amount.
- R8: Opcodes 8 (add), 9 (add without overflow) and 10 sign-extend instr[15:0] to form the second operand.
- R9: Opcodes 12, 13 and 14 give AND, OR and XOR of the rs value with instr[15:0] zero-extended.
- R10: Opcode 15 gives instr[15:0] in the upper 16 result bits and zero in the lower 16.
- R11: ovf_o is high for function 32, function 34 and opcode 8 exactly when the true signed result does not fit in 32 bits.
- R12: ovf_o is never high for function 33, function 35 or opcode 9, nor for any non-arithmetic operation.
- R13: Any opcode or function code not listed above sets illegal_o high, with result_o zero and ovf_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of first source register |
| rt_val_i | input | 32 | Value of second source register |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered illegal-instruction flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The only state is the output register, so a decode slip or a wrong operand choice appears one clock after the offending word, and only on that word's result. Nothing carries into later cycles. For this reason, every cycle is compared against a behavioural model that evaluates arithmetic on wide signed integers. Directed words cover overflow edges (largest positive plus one, most negative minus one, and the no-overflow twins of each), sign-extension of a negative immediate, zero-extension of a full immediate, an arithmetic shift of a negative value, a register shift amount above 31, and unused opcode and function codes. Random words drawn from legal and illegal codes follow.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLL, K_SRL, K_SRA, K_LUI, K_BAD
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;
        logic      sign_ext;
        logic      ovf_en;
        logic      amt_from_reg;
        logic      illegal;
    } dec_ctl_t;

    localparam logic [5:0] OP_REG   = 6'd0;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_ADDIU = 6'd9;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_XORI  = 6'd14;
    localparam logic [5:0] OP_LUI   = 6'd15;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] fn_i,
    output dec_ctl_t   ctl_o
);
    dec_ctl_t c_reg;
    dec_ctl_t c_imm;

    // register-form decode
    always_comb begin
        c_reg = '{kind: K_BAD, use_imm: 1'b0, sign_ext: 1'b0,
                  ovf_en: 1'b0, amt_from_reg: 1'b0, illegal: 1'b0};
        unique case (fn_i)
            FN_ADD:  begin c_reg.kind = K_ADD; c_reg.ovf_en = 1'b1; end
            FN_ADDU: c_reg.kind = K_ADD;
            FN_SUB:  begin c_reg.kind = K_SUB; c_reg.ovf_en = 1'b1; end
            FN_SUBU: c_reg.kind = K_SUB;
            FN_AND:  c_reg.kind = K_AND;
            FN_OR:   c_reg.kind = K_OR;
            FN_XOR:  c_reg.kind = K_XOR;
            FN_NOR:  c_reg.kind = K_NOR;
            FN_SLT:  c_reg.kind = K_SLT;
            FN_SLL:  c_reg.kind = K_SLL;
            FN_SRL:  c_reg.kind = K_SRL;
            FN_SRA:  c_reg.kind = K_SRA;
            FN_SLLV: begin c_reg.kind = K_SLL; c_reg.amt_from_reg = 1'b1; end
            FN_SRLV: begin c_reg.kind = K_SRL; c_reg.amt_from_reg = 1'b1; end
            FN_SRAV: begin c_reg.kind = K_SRA; c_reg.amt_from_reg = 1'b1; end
            default: c_reg.illegal = 1'b1;
        endcase
    end

    // immediate-form decode
    always_comb begin
        c_imm = '{kind: K_BAD, use_imm: 1'b1, sign_ext: 1'b0,
                  ovf_en: 1'b0, amt_from_reg: 1'b0, illegal: 1'b0};
        unique case (op_i)
            OP_ADDI:  begin c_imm.kind = K_ADD; c_imm.sign_ext = 1'b1; c_imm.ovf_en = 1'b1; end
            OP_ADDIU: begin c_imm.kind = K_ADD; c_imm.sign_ext = 1'b1; end
            OP_SLTI:  begin c_imm.kind = K_SLT; c_imm.sign_ext = 1'b1; end
            OP_ANDI:  c_imm.kind = K_AND;
            OP_ORI:   c_imm.kind = K_OR;
            OP_XORI:  c_imm.kind = K_XOR;
            OP_LUI:   c_imm.kind = K_LUI;
            default:  c_imm.illegal = 1'b1;
        endcase
    end

    assign ctl_o = (op_i == OP_REG) ? c_reg : c_imm;
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              right_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] res_o
);
    logic fill;
    logic [2*DATA_W-1:0] ext;
    logic [2*DATA_W-1:0] ext_sh;

    assign fill = arith_i & val_i[DATA_W-1];
    assign ext  = {{DATA_W{fill}}, val_i};
    assign ext_sh = ext >> amt_i;

    always_comb begin
        if (right_i) res_o = ext_sh[DATA_W-1:0];
        else         res_o = val_i << amt_i;
    end
endmodule

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  dec_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] rt_i,
    input  logic [AMT_W-1:0]  const_amt_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o
);
    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] sh_res;
    logic [AMT_W-1:0]  amt;
    logic              lt;

    assign is_sub = (ctl_i.kind == K_SUB);
    assign b_eff  = is_sub ? ~b_i : b_i;
    assign sum    = a_i + b_eff + {{(DATA_W-1){1'b0}}, is_sub};
    assign lt     = $signed(a_i) < $signed(b_i);
    assign amt    = ctl_i.amt_from_reg ? a_i[AMT_W-1:0] : const_amt_i;

    exu_shift #(.DATA_W(DATA_W)) i_shift (
        .val_i   (rt_i),
        .amt_i   (amt),
        .right_i (ctl_i.kind != K_SLL),
        .arith_i (ctl_i.kind == K_SRA),
        .res_o   (sh_res)
    );

    always_comb begin
        unique case (ctl_i.kind)
            K_ADD, K_SUB: res_o = sum;
            K_AND:        res_o = a_i & b_i;
            K_OR:         res_o = a_i | b_i;
            K_XOR:        res_o = a_i ^ b_i;
            K_NOR:        res_o = ~(a_i | b_i);
            K_SLT:        res_o = {{(DATA_W-1){1'b0}}, lt};
            K_SLL, K_SRL, K_SRA: res_o = sh_res;
            K_LUI:        res_o = {imm_i, {(DATA_W-IMM_W){1'b0}}};
            default:      res_o = '0;
        endcase
    end

    assign ovf_o = ctl_i.ovf_en & (a_i[DATA_W-1] == b_eff[DATA_W-1])
                   & (sum[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IMM_W = 16,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [DATA_W-1:0] rt_val_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o,
    output logic              ovf_o
);
    dec_ctl_t          ctl;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] res_d;
    logic              ovf_d;

    assign imm = instr_i[IMM_W-1:0];

    exu_decode i_dec (
        .op_i  (instr_i[31:26]),
        .fn_i  (instr_i[5:0]),
        .ctl_o (ctl)
    );

    assign imm_ext = ctl.sign_ext ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm}
                                  : {{(DATA_W-IMM_W){1'b0}}, imm};
    assign opnd_b  = ctl.use_imm ? imm_ext : rt_val_i;

    exu_arith #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_arith (
        .ctl_i       (ctl),
        .a_i         (rs_val_i),
        .b_i         (opnd_b),
        .rt_i        (rt_val_i),
        .const_amt_i (instr_i[6 +: AMT_W]),
        .imm_i       (imm),
        .res_o       (res_d),
        .ovf_o       (ovf_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
            ovf_o     <= 1'b0;
        end else begin
            result_o  <= ctl.illegal ? '0 : res_d;
            illegal_o <= ctl.illegal;
            ovf_o     <= ovf_d & ~ctl.illegal;
        end
    end
endmodule

// File: rtl/exu_top_chk.sv
module exu_top_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] result_o,
    input logic              illegal_o,
    input logic              ovf_o
);
    a_r13_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0 && !ovf_o));

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd9 ||
         (instr_i[31:26] == 6'd0 && (instr_i[5:0] == 6'd33 || instr_i[5:0] == 6'd35)))
        |=> !ovf_o);

    a_r10_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd15) |=> (result_o == {$past(instr_i[15:0]), {(DATA_W-16){1'b0}}}));

    a_r5_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd10) |=> (result_o[DATA_W-1:1] == '0 && !illegal_o));

    a_r9_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd12) |=> (result_o[DATA_W-1:16] == '0));

    a_r13_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd16) |=> illegal_o);
endmodule

bind exu_top exu_top_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .result_o  (result_o),
    .illegal_o (illegal_o),
    .ovf_o     (ovf_o)
);

// File: tb/test_exu_top.sv
`timescale 1ns/1ps
module test_exu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_v = '0;
    logic [31:0] rt_v = '0;
    logic [31:0] result;
    logic        illegal;
    logic        ovf;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    exu_top i_exu_top (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rs_val_i(rs_v),
        .rt_val_i(rt_v), .result_o(result), .illegal_o(illegal), .ovf_o(ovf)
    );

    function automatic logic [31:0] rw(input int fn, input int sh);
        return {6'd0, 5'd3, 5'd4, 5'd5, sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] iw(input int op, input logic [15:0] imm);
        return {op[5:0], 5'd1, 5'd2, imm};
    endfunction

    // behavioural model on wide integers
    task automatic model(input logic [31:0] ins, a, b,
                         output logic [31:0] r, output logic il, output logic ov,
                         output string tag);
        longint sa, sb, simm, wide;
        int op, fn;
        op = ins[31:26]; fn = ins[5:0];
        sa = longint'($signed(a)); sb = longint'($signed(b));
        simm = longint'($signed(ins[15:0]));
        r = 0; il = 0; ov = 0; tag = "R13";
        if (op == 0) begin
            case (fn)
                32, 33: begin wide = sa + sb; r = wide[31:0];
                        ov = (fn == 32) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
                        tag = (fn == 32) ? "R11" : "R3"; end
                34, 35: begin wide = sa - sb; r = wide[31:0];
                        ov = (fn == 34) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
                        tag = (fn == 34) ? "R11" : "R3"; end
                36: begin r = a & b; tag = "R4"; end
                37: begin r = a | b; tag = "R4"; end
                38: begin r = a ^ b; tag = "R4"; end
                39: begin r = ~(a | b); tag = "R4"; end
                42: begin r = (sa < sb) ? 1 : 0; tag = "R5"; end
                0:  begin r = b << ins[10:6]; tag = "R6"; end
                2:  begin r = b >> ins[10:6]; tag = "R6"; end
                3:  begin r = 32'(sb >>> ins[10:6]); tag = "R6"; end
                4:  begin r = b << a[4:0]; tag = "R7"; end
                6:  begin r = b >> a[4:0]; tag = "R7"; end
                7:  begin r = 32'(sb >>> a[4:0]); tag = "R7"; end
                default: il = 1;
            endcase
        end else begin
            case (op)
                8, 9: begin wide = sa + simm; r = wide[31:0];
                      ov = (op == 8) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
                      tag = "R8"; end
                10: begin r = (sa < simm) ? 1 : 0; tag = "R5"; end
                12: begin r = a & {16'd0, ins[15:0]}; tag = "R9"; end
                13: begin r = a | {16'd0, ins[15:0]}; tag = "R9"; end
                14: begin r = a ^ {16'd0, ins[15:0]}; tag = "R9"; end
                15: begin r = {ins[15:0], 16'd0}; tag = "R10"; end
                default: il = 1;
            endcase
        end
    endtask

    // R2: drive at a falling edge, result visible after the next rising edge
    task automatic run(input logic [31:0] ins, a, b);
        logic [31:0] er; logic eil, eov; string tag;
        model(ins, a, b, er, eil, eov, tag);
        instr = ins; rs_v = a; rt_v = b;
        @(posedge clk); @(negedge clk);
        checks++;
        if (result !== er || illegal !== eil || ovf !== eov) begin
            errors++;
            $display("FAIL %s/R2 instr=%h res=%h il=%b ov=%b expected res=%h il=%b ov=%b",
                     tag, ins, result, illegal, ovf, er, eil, eov);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        instr = iw(15, 16'hABCD); rs_v = 32'hFFFF_FFFF; rt_v = 32'h1234_5678;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 0 || illegal !== 0 || ovf !== 0) begin
            errors++;
            $display("FAIL R1 res=%h il=%b ov=%b expected 0 0 0", result, illegal, ovf);
        end
        rst_n = 1'b1;
        checks++;
        if (result !== 0 || illegal !== 0 || ovf !== 0) begin
            errors++;
            $display("FAIL R1 after release res=%h expected 0", result);
        end
        // R3 / R11 / R12 overflow corners
        run(rw(32, 0), 32'h7FFF_FFFF, 32'h1);
        run(rw(33, 0), 32'h7FFF_FFFF, 32'h1);
        run(rw(34, 0), 32'h8000_0000, 32'h1);
        run(rw(35, 0), 32'h8000_0000, 32'h1);
        run(rw(34, 0), 32'h0, 32'h8000_0000);
        run(rw(32, 0), 32'hFFFF_FFFF, 32'h8000_0000);
        run(rw(32, 0), 32'h5, 32'hFFFF_FFFD);
        // R4
        run(rw(36, 0), 32'hF0F0_1234, 32'h0FF0_FFFF);
        run(rw(39, 0), 32'hF0F0_0000, 32'h0000_000F);
        // R5 signed compare
        run(rw(42, 0), 32'hFFFF_FFFF, 32'h1);
        run(rw(42, 0), 32'h1, 32'hFFFF_FFFF);
        run(iw(10, 16'hFFFE), 32'hFFFF_FFFD, 32'h0);
        run(iw(10, 16'hFFFE), 32'hFFFF_FFFE, 32'h0);
        // R6 / R7 shifts
        run(rw(3, 4), 32'h0, 32'h8000_00F0);
        run(rw(2, 31), 32'h0, 32'h8000_0000);
        run(rw(0, 5), 32'h0, 32'h0000_0003);
        run(rw(7, 0), 32'd33, 32'h8000_0000);
        run(rw(6, 0), 32'hFFFF_FFE4, 32'hF000_0000);
        run(rw(4, 0), 32'd31, 32'h1);
        // R8 / R11 / R12 immediates
        run(iw(8, 16'hFFFF), 32'h10, 32'h0);
        run(iw(8, 16'h0001), 32'h7FFF_FFFF, 32'h0);
        run(iw(9, 16'h0001), 32'h7FFF_FFFF, 32'h0);
        run(iw(8, 16'h8000), 32'h8000_0000, 32'h0);
        // R9 zero extension
        run(iw(12, 16'hFFFF), 32'hFFFF_FFFF, 32'h0);
        run(iw(13, 16'h8000), 32'h0, 32'h0);
        run(iw(14, 16'hFFFF), 32'hAAAA_AAAA, 32'h0);
        // R10
        run(iw(15, 16'h003D), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R13 unused codes
        run(iw(16, 16'h1234), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run(rw(1, 3), 32'h1, 32'h1);
        run(rw(40, 0), 32'h7FFF_FFFF, 32'h1);
        run(iw(11, 16'h0001), 32'h1, 32'h1);
        // random mix of legal and unused codes
        for (int k = 0; k < 400; k++) begin
            int sel;
            logic [31:0] w;
            sel = $urandom_range(0, 3);
            w = $urandom;
            if (sel < 2) w[31:26] = 6'd0;
            else if (sel == 2) w[31:26] = 6'($urandom_range(8, 15));
            run(w, $urandom, $urandom);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule